// File: doc/BRIEF.md
# Carry select adder with plus-one group converter

This block is a purely combinational binary adder. It takes two operands of a parameterised width and a carry-in, and returns the sum together with the carry-out. The operand width is split into equal groups of bits. The lowest group is a plain ripple chain fed by the external carry. Each higher group works out its result before the carry from below arrives, and a multiplexer driven by that carry then picks the right result.

A higher group does not build its carry-in-one result with a second ripple chain. It runs one ripple chain that assumes a carry-in of zero. It then passes that (group width + 1)-bit result, sum and carry together, through a converter that adds one. This gives the carry-in-one result. The saving in full adders is paid for with one extra increment stage on each group's select path.

The block can replace any datapath adder that needs no pipelining and no overflow flag. The width must be a whole multiple of the group size. Any other combination is rejected when the design is elaborated.

Top module: `csa_bec_adder`

## Requirements
- R1: For every input, the 1-bit `cout` concatenated above the WIDTH-bit `sum` equals a + b + cin computed to WIDTH+1 bits.
- R2: The lowest group of GRP bits gives sum[GRP-1:0] and its group carry directly from a ripple of a, b and the external cin, with no converter or multiplexer in that path.
- R3: The plus-one converter in each higher group maps its (GRP+1)-bit input x to x + 1 modulo 2^(GRP+1). A carry-in-zero result of all ones (group sum all ones with a group carry of 0) becomes sum 0 with a group carry of 1.
- R4: In each higher group, an incoming carry of 0 selects the carry-in-zero ripple result, and an incoming carry of 1 selects the converter output. Both the sum bits and the group carry-out are selected this way.
- R5: WIDTH values of 8, 16, 32 and 64 all meet R1. At WIDTH 8, R1 holds for all 2^17 combinations of a, b and cin.
- R6: A carry entering at bit 0 propagates through every group. With a all ones, b zero and cin 1, the result is sum 0 and cout 1.
- R7: The group size GRP is a parameter that defaults to 4. A non-default GRP of 8 at WIDTH 32 also meets R1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | WIDTH | First operand |
| b | input | WIDTH | Second operand |
| cin | input | 1 | Carry into bit 0 |
| sum | output | WIDTH | Low WIDTH bits of a + b + cin |
| cout | output | 1 | Carry out of the most significant group |

## Verification
Several vectors target the places where the converter and the select logic are most exposed.

- **Group sum of all ones.** These vectors make a group's carry-in-zero sum all ones with a select carry of 1, so the converter must wrap to zero and raise the group carry. A converter that drops its top bit, or that mis-forms the AND of the lower bits, would then lose the carry into the next group.
- **Full carry propagation.** All-ones operands with cin set drive a carry through every group. A multiplexer wired to the wrong group's carry, or that selects only the sum and not the group carry, would give a wrong upper sum or a wrong `cout`.
- **Every pattern at 8 bits.** The exhaustive 8-bit sweep covers every input pattern of the smallest configuration.
- **Other widths and group size.** Alternating-bit patterns and random operands at the other widths, and at the group size of 8, check that the generated group chain scales.

// File: rtl/csa_pkg.sv
package csa_pkg;
    // Default number of bits handled by one carry-select group (R7)
    localparam int DEF_GRP = 4;

    // Number of groups for a given operand width and group size
    function automatic int grp_count(input int width, input int grp);
        return width / grp;
    endfunction
endpackage

// File: rtl/csa_rca.sv
// Ripple chain of explicit full adders, N bits wide
module csa_rca #(
    parameter int N = 4
) (
    input  logic [N-1:0] a,
    input  logic [N-1:0] b,
    input  logic         ci,
    output logic [N-1:0] s,
    output logic         co
);
    logic [N:0] c;

    assign c[0] = ci;

    for (genvar i = 0; i < N; i++) begin : g_fa
        assign s[i]   = a[i] ^ b[i] ^ c[i];
        assign c[i+1] = (a[i] & b[i]) | (c[i] & (a[i] ^ b[i]));
    end

    assign co = c[N];

    // R2: the chain must equal an arithmetic add of its own inputs
    always_comb begin
        a_r2_ripple_exact: assert ({co, s} == ({1'b0, a} + {1'b0, b} + {{N{1'b0}}, ci}))
            else $error("ripple chain result mismatch");
    end
endmodule

// File: rtl/csa_excess1.sv
// Plus-one (excess-1) converter, W bits wide, wraps modulo 2^W
module csa_excess1 #(
    parameter int W = 5
) (
    input  logic [W-1:0] x,
    output logic [W-1:0] y
);
    logic [W-1:0] run_and;

    assign run_and[0] = 1'b1;
    assign y[0]       = ~x[0];

    for (genvar i = 1; i < W; i++) begin : g_bit
        assign run_and[i] = run_and[i-1] & x[i-1];
        assign y[i]       = x[i] ^ run_and[i];
    end

    // R3: output is input plus one, with wrap at all ones
    always_comb begin
        a_r3_plus_one: assert (y == x + W'(1))
            else $error("excess-1 converter mismatch");
    end
endmodule

// File: rtl/csa_bec_grp.sv
// One upper group: one ripple chain, one plus-one converter, one selector
module csa_bec_grp #(
    parameter int N = 4
) (
    input  logic [N-1:0] a,
    input  logic [N-1:0] b,
    input  logic         csel,
    output logic [N-1:0] s,
    output logic         co
);
    logic [N-1:0] s_zero;
    logic         c_zero;
    logic [N:0]   inc_out;

    csa_rca #(.N(N)) u_rca (
        .a  (a),
        .b  (b),
        .ci (1'b0),
        .s  (s_zero),
        .co (c_zero)
    );

    csa_excess1 #(.W(N + 1)) u_inc (
        .x ({c_zero, s_zero}),
        .y (inc_out)
    );

    always_comb begin
        if (csel) begin
            {co, s} = inc_out;
        end else begin
            {co, s} = {c_zero, s_zero};
        end
    end

    // R4: the selected group result equals the add with the incoming carry
    always_comb begin
        a_r4_select_exact: assert ({co, s} == ({1'b0, a} + {1'b0, b} + {{N{1'b0}}, csel}))
            else $error("group select mismatch");
    end
endmodule

// File: rtl/csa_bec_adder.sv
// Top: carry select adder whose upper groups use a plus-one converter
module csa_bec_adder #(
    parameter int WIDTH = 32,
    parameter int GRP   = csa_pkg::DEF_GRP
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             cin,
    output logic [WIDTH-1:0] sum,
    output logic             cout
);
    localparam int NGRP = csa_pkg::grp_count(WIDTH, GRP);

    // Group carries: gc[g] is the carry into group g
    logic [NGRP:0] gc;

    if ((WIDTH % GRP) != 0 || WIDTH < GRP) begin : g_bad_width
        $error("WIDTH must be a positive multiple of GRP");
    end

    assign gc[0] = cin;

    // R2: lowest group is a bare ripple chain on the external carry
    csa_rca #(.N(GRP)) u_low (
        .a  (a[GRP-1:0]),
        .b  (b[GRP-1:0]),
        .ci (gc[0]),
        .s  (sum[GRP-1:0]),
        .co (gc[1])
    );

    for (genvar g = 1; g < NGRP; g++) begin : g_grp
        csa_bec_grp #(.N(GRP)) u_grp (
            .a    (a[g*GRP +: GRP]),
            .b    (b[g*GRP +: GRP]),
            .csel (gc[g]),
            .s    (sum[g*GRP +: GRP]),
            .co   (gc[g+1])
        );
    end

    assign cout = gc[NGRP];

    // R1: whole-word result equals the arithmetic sum
    always_comb begin
        a_r1_word_exact: assert ({cout, sum} == ({1'b0, a} + {1'b0, b} + {{WIDTH{1'b0}}, cin}))
            else $error("adder word mismatch");
    end

    // R6: all-ones plus carry-in must wrap to zero with carry out
    always_comb begin
        if (a == {WIDTH{1'b1}} && b == '0 && cin) begin
            a_r6_full_propagate: assert (sum == '0 && cout)
                else $error("full carry propagation failed");
        end
    end
endmodule

// File: tb/csa_bec_adder_tb.sv
module csa_bec_adder_tb;
    logic clk = 1'b0;
    always #2 clk = ~clk;   // 250 MHz

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    logic [7:0]  a8,  b8;  logic c8;  logic [7:0]  s8;  logic co8;
    logic [15:0] a16, b16; logic c16; logic [15:0] s16; logic co16;
    logic [31:0] a32, b32; logic c32; logic [31:0] s32; logic co32;
    logic [63:0] a64, b64; logic c64; logic [63:0] s64; logic co64;
    logic [31:0] ag,  bg;  logic cg;  logic [31:0] sg;  logic cog;

    csa_bec_adder #(.WIDTH(32)) u_dut (.a(a32), .b(b32), .cin(c32), .sum(s32), .cout(co32));
    csa_bec_adder #(.WIDTH(8))  u_w8  (.a(a8),  .b(b8),  .cin(c8),  .sum(s8),  .cout(co8));
    csa_bec_adder #(.WIDTH(16)) u_w16 (.a(a16), .b(b16), .cin(c16), .sum(s16), .cout(co16));
    csa_bec_adder #(.WIDTH(64)) u_w64 (.a(a64), .b(b64), .cin(c64), .sum(s64), .cout(co64));
    csa_bec_adder #(.WIDTH(32), .GRP(8)) u_g8 (.a(ag), .b(bg), .cin(cg), .sum(sg), .cout(cog));

    function automatic logic [64:0] ref_add(input int w, input logic [63:0] x,
                                            input logic [63:0] y, input logic ci);
        logic [64:0] full;
        logic [64:0] mask;
        full = {1'b0, x} + {1'b0, y} + {64'd0, ci};
        mask = (65'd1 << (w + 1)) - 65'd1;
        return full & mask;
    endfunction

    task automatic chk(input string req, input int w, input logic [64:0] got,
                       input logic [64:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s width=%0d actual=%h expected=%h", req, w, got, exp);
        end
    endtask

    task automatic drive(input logic [63:0] x, input logic [63:0] y, input logic ci);
        a8 = x[7:0];   b8 = y[7:0];   c8 = ci;
        a16 = x[15:0]; b16 = y[15:0]; c16 = ci;
        a32 = x[31:0]; b32 = y[31:0]; c32 = ci;
        a64 = x;       b64 = y;       c64 = ci;
        ag = x[31:0];  bg = y[31:0];  cg = ci;
    endtask

    task automatic check_wide(input string req);
        chk(req, 16, {48'd0, co16, s16}, ref_add(16, {48'd0, a16}, {48'd0, b16}, c16));
        chk(req, 32, {32'd0, co32, s32}, ref_add(32, {32'd0, a32}, {32'd0, b32}, c32));
        chk(req, 64, {co64, s64},        ref_add(64, a64, b64, c64));
        chk("R7", 32, {32'd0, cog, sg},  ref_add(32, {32'd0, ag}, {32'd0, bg}, cg));
    endtask

    task automatic check_all(input string req);
        chk(req, 8, {56'd0, co8, s8}, ref_add(8, {56'd0, a8}, {56'd0, b8}, c8));
        check_wide(req);
    endtask

    task automatic directed(input logic [63:0] x, input logic [63:0] y,
                            input logic ci, input string req);
        @(posedge clk);
        drive(x, y, ci);
        @(negedge clk);
        check_all(req);
    endtask

    initial begin
        void'($urandom(32'h5eed_c5a1));
        drive(64'd0, 64'd0, 1'b0);

        // All zeros: quiet outputs
        @(negedge clk);
        chk("R1", 32, {32'd0, co32, s32}, 65'd0);
        check_all("R1");

        // R6: carry entering at bit 0 ripples through every group
        directed({64{1'b1}}, 64'd0, 1'b1, "R6");
        chk("R6", 64, {co64, s64}, {1'b1, 64'd0});

        // R3 / R4: upper groups see all-ones carry-in-zero sums with select 1
        directed({64{1'b1}}, 64'd1, 1'b0, "R3");
        directed(64'h0F0F_0F0F_0F0F_0F0F, 64'h00F0_00F0_00F0_00F1, 1'b0, "R4");
        directed({64{1'b1}}, {64{1'b1}}, 1'b1, "R4");
        directed(64'h7777_7777_7777_7777, 64'h8888_8888_8888_8888, 1'b1, "R3");

        // Alternating-bit patterns
        directed({32{2'b10}}, {32{2'b01}}, 1'b0, "R1");
        directed({32{2'b10}}, {32{2'b01}}, 1'b1, "R1");
        directed({32{2'b10}}, {32{2'b10}}, 1'b1, "R1");

        // R2: low group taken straight from the external carry
        directed(64'h0000_0000_0000_0007, 64'h0000_0000_0000_0008, 1'b1, "R2");
        chk("R2", 32, {61'd0, s32[3:0]}, 65'd0);
        chk("R2", 32, {64'd0, s32[4]}, 65'd1);
        directed(64'h0000_0000_0000_0003, 64'h0000_0000_0000_0004, 1'b0, "R2");
        chk("R2", 32, {61'd0, s32[3:0]}, 65'd7);

        // R5: exhaustive 8-bit sweep, random vectors at other widths
        for (int i = 0; i < (1 << 17); i++) begin
            @(posedge clk);
            drive({$urandom, $urandom}, {$urandom, $urandom}, 1'($urandom));
            a8 = i[7:0];
            b8 = i[15:8];
            c8 = i[16];
            @(negedge clk);
            chk("R5", 8, {56'd0, co8, s8}, ref_add(8, {56'd0, a8}, {56'd0, b8}, c8));
            if (i % 16 == 0) begin
                check_wide("R1");
            end
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R1 watchdog actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule